// File: doc/BRIEF.md
# Timed-Access Write Guard

The block protects a small group of control registers from accidental writes. Software opens a short write window by writing a two-byte key to a dedicated unlock register, at address C7h. The first key byte is AAh and the second is 55h. The second byte must arrive within a tight tick budget after the first. Once the window is open, writes to protected registers are accepted for a fixed number of machine-cycle ticks. After that the window closes by itself.

Writes to protected registers outside the window are dropped without notice. Reads are never gated. A machine-cycle tick input (`cyc_tick`) drives both the deadline and the window length, so the limits are counted in machine cycles and not in raw clocks.

A bus write takes effect on the clock edge where `bus_we` is high. If a key write and a tick fall on the same edge, the write is handled first.

The sequencer has three states:
- `ST_IDLE`: no key is pending.
- `ST_ARMED`: AAh has been seen and the sequencer is waiting for 55h.
- `ST_OPEN`: the write window is open.

It has six transitions:
- `arm`: ST_IDLE to ST_ARMED on an AAh write.
- `rearm`: ST_ARMED to ST_ARMED on another AAh write, which restarts the count.
- `unlock`: ST_ARMED to ST_OPEN on a 55h write.
- `abandon`: ST_ARMED to ST_IDLE on any other key value.
- `expire`: ST_ARMED to ST_IDLE on the third tick.
- `close`: ST_OPEN to ST_IDLE on the fourth tick.

Top module: `ta_guard`

## Requirements
- R1: After reset, `window_open` is 0. Every example register reads 00h. A read of the unlock register at C7h returns 00h, because that register is write-only.
- R2: An AAh write to C7h followed by a 55h write to C7h opens the window when the 55h write happens before the third tick after the AAh write is counted. A 55h write on the same edge as that third tick also counts. Clock edges without a tick do not count toward the limit. `window_open` is 1 in the cycle after the 55h write.
- R3: If three ticks elapse after the AAh write before 55h is written, the pending key is dropped and a later 55h write leaves `window_open` at 0.
- R4: The window stays open for exactly 4 ticks after the 55h write. It closes on the edge of the fourth tick. A protected write on that same edge is still accepted.
- R5: A write to a protected register while `window_open` is 0 is discarded, and the register keeps its previous value.
- R6: While the window is open, more than one protected write is accepted. Each written value reads back on the next cycle.
- R7: Reads of any register need no unlock. The unprotected register D2h accepts writes at any time.
- R8: A 55h write with no AAh pending does not open the window. A write of any value other than 55h or AAh while AAh is pending clears the pending state, so a following 55h does not open the window.
- R9: An AAh write while AAh is already pending restarts the three-tick limit.
- R10: `addr_protected` is 1 when `bus_addr` selects D0h or D1h, which are protected. It is 0 for D2h and for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_tick | input | 1 | Machine-cycle clock enable |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| window_open | output | 1 | The protected-write window is open |
| addr_protected | output | 1 | `bus_addr` selects a protected register |

## Verification
A write, whether a key byte or register data, shows its effect one clock after the edge on which it was strobed. `window_open` and the register contents change on that edge. `bus_rdata` and `addr_protected` are combinational in `bus_addr`.

The bench drives every input on the falling edge and holds it through one rising edge. It then samples on the following falling edge, so each result is read exactly one register stage after its cause. Tick counts are built edge by edge, so the deadline and window boundaries land on a known edge. Each boundary is probed on both sides.

// File: rtl/ta_pkg.sv
package ta_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_OPEN  = 2'd2
    } ta_state_e;

    localparam logic [7:0] KEY_FIRST  = 8'hAA;
    localparam logic [7:0] KEY_SECOND = 8'h55;
endpackage

// File: rtl/ta_seq_fsm.sv
module ta_seq_fsm
    import ta_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 3,
    parameter int WINDOW_TICKS  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_tick,
    input  logic       key_wr,
    input  logic [7:0] key_data,
    output logic       window_open
);
    localparam int MAXT = (TIMEOUT_TICKS > WINDOW_TICKS) ? TIMEOUT_TICKS : WINDOW_TICKS;
    localparam int CW   = $clog2(MAXT + 1);
    localparam logic [CW-1:0] TO_LAST  = CW'(TIMEOUT_TICKS - 1);
    localparam logic [CW-1:0] WIN_LAST = CW'(WINDOW_TICKS - 1);

    ta_state_e     state, state_nx;
    logic [CW-1:0] cnt, cnt_nx;

    // next-state logic
    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        unique case (state)
            ST_IDLE: begin
                if (key_wr && key_data == KEY_FIRST) begin
                    state_nx = ST_ARMED;   // arm
                    cnt_nx   = '0;
                end
            end
            ST_ARMED: begin
                if (key_wr) begin
                    cnt_nx = '0;
                    if (key_data == KEY_SECOND)     state_nx = ST_OPEN;   // unlock
                    else if (key_data == KEY_FIRST) state_nx = ST_ARMED;  // rearm
                    else                            state_nx = ST_IDLE;   // abandon
                end else if (cyc_tick) begin
                    if (cnt == TO_LAST) begin
                        state_nx = ST_IDLE;         // expire
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
            end
            ST_OPEN: begin
                if (cyc_tick) begin
                    if (cnt == WIN_LAST) begin
                        state_nx = ST_IDLE;         // close
                        cnt_nx   = '0;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
            end
            default: begin
                state_nx = ST_IDLE;
                cnt_nx   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    // outputs
    always_comb begin
        window_open = (state == ST_OPEN);
    end

    p_open_after_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(window_open) |-> $past(key_wr && key_data == KEY_SECOND && state == ST_ARMED));
    p_deadline_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ARMED) |-> (cnt < CW'(TIMEOUT_TICKS)));
    p_window_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OPEN) |-> (cnt < CW'(WINDOW_TICKS)));
    p_no_stray_unlock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && key_wr && key_data != KEY_FIRST) |=> (state == ST_IDLE));
endmodule

// File: rtl/ta_prot_regs.sv
module ta_prot_regs #(
    parameter int          NUM_REGS  = 3,
    parameter logic [7:0]  REG_BASE  = 8'hD0,
    parameter logic [NUM_REGS-1:0] PROT_MASK = 3'b011
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       window_open,
    input  logic       bus_we,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] rd_data,
    output logic       rd_hit,
    output logic       addr_protected
);
    logic [7:0]          q   [NUM_REGS];
    logic [NUM_REGS-1:0] hit;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        localparam logic [7:0] MY_ADDR = REG_BASE + 8'(i);
        assign hit[i] = (bus_addr == MY_ADDR);
        logic wen;
        assign wen = bus_we && hit[i] && (!PROT_MASK[i] || window_open);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q[i] <= '0;
            else if (wen) q[i] <= bus_wdata;
        end

        if (PROT_MASK[i]) begin : g_chk
            p_discard_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_we && hit[i] && !window_open) |=> $stable(q[i]));
            p_accept_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (bus_we && hit[i] && window_open) |=> (q[i] == $past(bus_wdata)));
        end
    end

    always_comb begin
        rd_data        = '0;
        addr_protected = 1'b0;
        for (int k = 0; k < NUM_REGS; k++) begin
            if (hit[k]) begin
                rd_data        = q[k];
                addr_protected = PROT_MASK[k];
            end
        end
    end

    assign rd_hit = |hit;

    p_one_hit_r10: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit));
endmodule

// File: rtl/ta_guard.sv
module ta_guard #(
    parameter logic [7:0] KEY_ADDR      = 8'hC7,
    parameter int         TIMEOUT_TICKS = 3,
    parameter int         WINDOW_TICKS  = 4,
    parameter int         NUM_REGS      = 3,
    parameter logic [7:0] REG_BASE      = 8'hD0,
    parameter logic [NUM_REGS-1:0] PROT_MASK = 3'b011
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_tick,
    input  logic       bus_we,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       window_open,
    output logic       addr_protected
);
    logic       key_wr;
    logic [7:0] reg_rd;
    logic       reg_hit;

    assign key_wr = bus_we && (bus_addr == KEY_ADDR);

    ta_seq_fsm #(
        .TIMEOUT_TICKS(TIMEOUT_TICKS),
        .WINDOW_TICKS (WINDOW_TICKS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cyc_tick   (cyc_tick),
        .key_wr     (key_wr),
        .key_data   (bus_wdata),
        .window_open(window_open)
    );

    ta_prot_regs #(
        .NUM_REGS (NUM_REGS),
        .REG_BASE (REG_BASE),
        .PROT_MASK(PROT_MASK)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .window_open   (window_open),
        .bus_we        (bus_we),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .rd_data       (reg_rd),
        .rd_hit        (reg_hit),
        .addr_protected(addr_protected)
    );

    // unlock register is write-only: reads return zero
    assign bus_rdata = reg_hit ? reg_rd : 8'h00;

    p_key_reads_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == KEY_ADDR) |-> (bus_rdata == 8'h00));
endmodule

// File: tb/ta_guard_tb.sv
module ta_guard_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_tick = 1'b0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       window_open;
    logic       addr_protected;

    int checks = 0;
    int errors = 0;

    localparam logic [7:0] KA = 8'hC7;
    localparam logic [7:0] R0 = 8'hD0, R1A = 8'hD1, R2A = 8'hD2;

    always #2.5 clk = ~clk;

    ta_guard u_dut (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .window_open(window_open), .addr_protected(addr_protected)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one bus write, optionally coinciding with a tick; returns at negedge
    task automatic wr(input logic [7:0] a, input logic [7:0] d, input logic t);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; cyc_tick = t;
        @(posedge clk); @(negedge clk);
        bus_we = 1'b0; cyc_tick = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            cyc_tick = 1'b1;
            @(posedge clk); @(negedge clk);
            cyc_tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a; #0.5; d = bus_rdata;
    endtask

    task automatic t_reset;
        logic [7:0] d;
        check("R1 window after reset", window_open, 0);
        rd(R0, d);  check("R1 D0 reset", d, 8'h00);
        rd(R2A, d); check("R1 D2 reset", d, 8'h00);
        rd(KA, d);  check("R1 key reads zero", d, 8'h00);
    endtask

    task automatic t_prot_flag;
        bus_addr = R0;  #0.5; check("R10 D0 protected", addr_protected, 1);
        bus_addr = R1A; #0.5; check("R10 D1 protected", addr_protected, 1);
        bus_addr = R2A; #0.5; check("R10 D2 unprotected", addr_protected, 0);
        bus_addr = KA;  #0.5; check("R10 key not flagged", addr_protected, 0);
    endtask

    task automatic t_closed_write;
        logic [7:0] d;
        wr(R0, 8'h99, 1'b0);
        rd(R0, d); check("R5 closed write dropped", d, 8'h00);
        wr(R2A, 8'h4B, 1'b0);
        rd(R2A, d); check("R7 unprotected write", d, 8'h4B);
    endtask

    task automatic t_unlock_window;
        logic [7:0] d;
        wr(KA, 8'hAA, 1'b0);
        wr(KA, 8'h55, 1'b1);
        check("R2 window opens", window_open, 1);
        wr(R0, 8'h5A, 1'b1);        // tick 1
        rd(R0, d); check("R6 first write", d, 8'h5A);
        wr(R1A, 8'h3C, 1'b1);       // tick 2
        rd(R1A, d); check("R6 second write", d, 8'h3C);
        ticks(1);                   // tick 3
        check("R4 open after 3 ticks", window_open, 1);
        wr(R0, 8'h77, 1'b1);        // tick 4 closes
        check("R4 closed after 4 ticks", window_open, 0);
        rd(R0, d); check("R4 write on last tick kept", d, 8'h77);
        wr(R0, 8'h11, 1'b0);
        rd(R0, d); check("R5 write after close dropped", d, 8'h77);
        rd(R1A, d); check("R7 read needs no unlock", d, 8'h3C);
    endtask

    task automatic t_deadline;
        wr(KA, 8'hAA, 1'b0);
        idle(6);                    // clocks without tick do not count
        ticks(2);
        wr(KA, 8'h55, 1'b1);        // coincides with third tick
        check("R2 55h on third tick opens", window_open, 1);
        ticks(4);
        check("R4 closes after drain", window_open, 0);
        wr(KA, 8'hAA, 1'b0);
        ticks(3);
        wr(KA, 8'h55, 1'b0);
        check("R3 late 55h stays closed", window_open, 0);
    endtask

    task automatic t_bad_keys;
        logic [7:0] d;
        wr(KA, 8'h55, 1'b0);
        check("R8 lone 55h", window_open, 0);
        wr(KA, 8'hAA, 1'b0);
        wr(KA, 8'h12, 1'b0);
        wr(KA, 8'h55, 1'b0);
        check("R8 wrong byte clears pending", window_open, 0);
        wr(R1A, 8'hEE, 1'b0);
        rd(R1A, d); check("R8 protected still locked", d, 8'h3C);
    endtask

    task automatic t_restart;
        wr(KA, 8'hAA, 1'b0);
        ticks(2);
        wr(KA, 8'hAA, 1'b0);
        ticks(2);
        wr(KA, 8'h55, 1'b0);
        check("R9 rearm restarts deadline", window_open, 1);
        ticks(4);
        check("R9 window drained", window_open, 0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prot_flag();
        t_closed_write();
        t_unlock_window();
        t_deadline();
        t_bad_keys();
        t_restart();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule